// File: doc/BRIEF.md
# Keyboard Wake Interrupt Latch

This block watches nine input pins: an eight-bit port A and a lone pin B0. Each pin can be chosen as a keyboard source through its own enable bit. When a chosen pin goes from high to low, one shared sticky latch is set. That latch drives a single interrupt request, plus a wake signal for logic that brings back a stopped clock. All nine sources share this one request. Software finds out which key was pressed by reading the port data, which happens outside this block.

The latch stays set until software writes a one to a clear bit in the mode control register. That clear bit always reads as zero. A master enable in the same register gates whether any request is produced at all. Enabling a port A pin as a key source also forces that pin's direction to input and turns its pull-up on. The block reports both of these through outputs.

Every pin passes through a two-stage synchroniser before the edge detector. As a result, the request rises on the third rising clock edge after a pin falls.

Top module: `kbd_wake_irq`

## Requirements
- R1: After synchronous reset, all enables and the master enable are 0, the latch is clear, and irq_req, wake_req, a_dir_force_in and a_pullup_on are all 0.
- R2: With the master enable set (mode register bit 7), a high-to-low change on port A pin n with key enable bit n set makes irq_req 1 on the third rising clock edge after the change, and not before.
- R3: Pin B0 is a key source when bit 0 of the port B direction register (select 1) is set. Its falling edge sets the latch like a port A pin.
- R4: A falling edge on a pin whose enable bit is 0 leaves irq_req at 0.
- R5: A rising edge on an enabled pin leaves irq_req at 0.
- R6: While the master enable is 0, irq_req stays 0, and a falling edge during that time is not recorded for later.
- R7: Once set, the request stays 1 through any number of cycles and after the pin returns high, until a clear is written.
- R8: Writing the mode register (select 2) with bit 6 = 1 and bit 7 = 1 clears the request on the next clock edge. A write with bit 6 = 0 leaves it set. Bit 6 always reads 0.
- R9: If an enabled falling edge is detected in the same cycle as a clear write, the latch stays set.
- R10: a_dir_force_in and a_pullup_on both equal the port A key enable register (select 0).
- R11: wake_req is 1 exactly when irq_req is 1.
- R12: Register reads return the written key enables (select 0), the B0 enable in bit 0 (select 1), and the master enable in bit 7 (select 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_a_in | input | 8 | Raw port A pin levels |
| pin_b0_in | input | 1 | Raw level of pin B0 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 key enables, 1 port B direction, 2 mode control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 8 | Read data for rd_sel |
| irq_req | output | 1 | Shared keyboard interrupt request |
| wake_req | output | 1 | Wake indication for a stopped clock |
| a_dir_force_in | output | 8 | Per-pin force-to-input for port A |
| a_pullup_on | output | 8 | Per-pin pull-up connection for port A |

## Verification
A table of pin transitions is driven through the latch under different enable masks. The patterns are single enabled falls at the low and high ends of port A, a fall on a disabled neighbour, a fall on B0 with and without its enable, rising edges on every pin, and several pins falling together with only some of them enabled. Together these separate per-pin enable masking from edge polarity, and they separate the B0 enable from the port A enables. Directed runs then check the exact edge on which the request rises, the stickiness over a long idle stretch, clear writes with the bit set and with the bit clear, a fall that lands in the same cycle as a clear, and edges that arrive while the master enable is off.

// File: rtl/kbw_pkg.sv
package kbw_pkg;
    localparam int unsigned PORT_W    = 8;
    localparam int unsigned SRC_W     = PORT_W + 1;
    localparam int unsigned REG_W     = 8;
    localparam int unsigned MASTER_BIT = 7;
    localparam int unsigned CLEAR_BIT  = 6;
    localparam int unsigned B0_EN_BIT  = 0;

    typedef enum logic [1:0] {
        SEL_KEYEN = 2'd0,
        SEL_DIRB  = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] a_en;
        logic              b0_en;
        logic              master;
    } kbw_cfg_t;

    function automatic logic any_hit(input logic [SRC_W-1:0] fall,
                                     input logic [SRC_W-1:0] en);
        return |(fall & en);
    endfunction
endpackage

// File: rtl/kbw_sync.sv
module kbw_sync #(
    parameter int unsigned W      = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '1;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '1;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/kbw_fall_detect.sv
module kbw_fall_detect #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cur;
    end

    assign fall = prev & ~cur;
endmodule

// File: rtl/kbw_cfg_regs.sv
module kbw_cfg_regs
    import kbw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output kbw_cfg_t         cfg,
    output logic             clr_pulse
);
    reg_sel_e wsel, rsel;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            unique case (wsel)
                SEL_KEYEN: cfg.a_en   <= wr_data[PORT_W-1:0];
                SEL_DIRB:  cfg.b0_en  <= wr_data[B0_EN_BIT];
                SEL_MODE:  cfg.master <= wr_data[MASTER_BIT];
                default: ;
            endcase
        end
    end

    assign clr_pulse = wr_en && (wsel == SEL_MODE) && wr_data[CLEAR_BIT];

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_KEYEN: rd_data[PORT_W-1:0] = cfg.a_en;
            SEL_DIRB:  rd_data[B0_EN_BIT]  = cfg.b0_en;
            SEL_MODE:  rd_data[MASTER_BIT] = cfg.master;
            default: ;
        endcase
    end
endmodule

// File: rtl/kbw_latch.sv
module kbw_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/kbd_wake_irq.sv
module kbd_wake_irq
    import kbw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port_a_in,
    input  logic              pin_b0_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_req,
    output logic              wake_req,
    output logic [PORT_W-1:0] a_dir_force_in,
    output logic [PORT_W-1:0] a_pullup_on
);
    kbw_cfg_t         cfg;
    logic             clr_pulse;
    logic [SRC_W-1:0] raw_vec, sync_vec, fall_vec, en_vec;
    logic             hit, latched;

    assign raw_vec = {pin_b0_in, port_a_in};

    kbw_cfg_regs u_cfg (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .cfg(cfg), .clr_pulse(clr_pulse)
    );

    kbw_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_vec), .q(sync_vec)
    );

    kbw_fall_detect #(.W(SRC_W)) u_fall (
        .clk(clk), .rst(rst), .cur(sync_vec), .fall(fall_vec)
    );

    assign en_vec = {cfg.b0_en, cfg.a_en};
    assign hit    = cfg.master && any_hit(fall_vec, en_vec);

    kbw_latch u_latch (
        .clk(clk), .rst(rst), .set(hit), .clr(clr_pulse), .q(latched)
    );

    assign irq_req        = latched && cfg.master;
    assign wake_req       = irq_req;
    assign a_dir_force_in = cfg.a_en;
    assign a_pullup_on    = cfg.a_en;
endmodule

// File: rtl/kbd_wake_irq_chk.sv
module kbd_wake_irq_chk
    import kbw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [REG_W-1:0]  wr_data,
    input logic [1:0]        rd_sel,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq_req,
    input logic [PORT_W-1:0] a_dir_force_in,
    input logic              master,
    input logic              hit,
    input logic [SRC_W-1:0]  fall_vec
);
    logic mode_wr;
    assign mode_wr = wr_en && (wr_sel == 2'd2);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_req && a_dir_force_in == '0));

    p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> ($past(hit) || $past(mode_wr)));

    p_masked_r6: assert property (@(posedge clk) disable iff (rst)
        !master |-> !irq_req);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !mode_wr) |=> irq_req);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && wr_data[6] && fall_vec == '0) |=> !irq_req);

    p_clear_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd2) |-> !rd_data[6]);

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && wr_data[6] && wr_data[7] && hit) |=> irq_req);
endmodule

bind kbd_wake_irq kbd_wake_irq_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_req(irq_req),
    .a_dir_force_in(a_dir_force_in), .master(cfg.master), .hit(hit),
    .fall_vec(fall_vec)
);

// File: tb/kbd_wake_irq_tb.sv
`timescale 1ns/1ps
module kbd_wake_irq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] port_a_in = 8'hFF;
    logic       pin_b0_in = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_sel = 2'd3;
    logic [7:0] rd_data;
    logic       irq_req, wake_req;
    logic [7:0] a_dir_force_in, a_pullup_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    kbd_wake_irq u_dut (
        .clk(clk), .rst(rst), .port_a_in(port_a_in), .pin_b0_in(pin_b0_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_req(irq_req),
        .wake_req(wake_req), .a_dir_force_in(a_dir_force_in),
        .a_pullup_on(a_pullup_on)
    );

    typedef struct packed {
        logic [7:0] en_a;
        logic       en_b;
        logic [7:0] a0;
        logic [7:0] a1;
        logic       b0;
        logic       b1;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h01, 1'b0, 8'hFF, 8'hFE, 1'b1, 1'b1, 1'b1},  // R2 pin 0
        '{8'h80, 1'b0, 8'hFF, 8'h7F, 1'b1, 1'b1, 1'b1},  // R2 pin 7
        '{8'h01, 1'b0, 8'hFF, 8'hFD, 1'b1, 1'b1, 1'b0},  // R4 neighbour
        '{8'h00, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1},  // R3 B0
        '{8'hFF, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0},  // R4 B0 off
        '{8'hFF, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0},  // R5 rising
        '{8'h0F, 1'b0, 8'hFF, 8'h0F, 1'b1, 1'b1, 1'b0},  // R4 upper off
        '{8'h3C, 1'b0, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b1}   // R2 many
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
        rd_sel = 2'd3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {7'b0, irq_req}, 8'h00);
        chk("R1 wake", {7'b0, wake_req}, 8'h00);
        chk("R1 force", a_dir_force_in, 8'h00);
        rd(2'd0, v); chk("R1 keyen", v, 8'h00);
        rd(2'd2, v); chk("R1 mode", v, 8'h00);

        wr(2'd2, 8'h80);
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, VECS[i].en_a);
            wr(2'd1, {7'b0, VECS[i].en_b});
            port_a_in = VECS[i].a0; pin_b0_in = VECS[i].b0;
            idle(5);
            wr(2'd2, 8'hC0);
            chk("R8 table clear", {7'b0, irq_req}, 8'h00);
            port_a_in = VECS[i].a1; pin_b0_in = VECS[i].b1;
            idle(4);
            chk("R2/R3/R4/R5 table", {7'b0, irq_req}, {7'b0, VECS[i].exp});
            chk("R11 table", {7'b0, wake_req}, {7'b0, VECS[i].exp});
        end

        // R10 and R12
        wr(2'd0, 8'hA5);
        chk("R10 force", a_dir_force_in, 8'hA5);
        chk("R10 pullup", a_pullup_on, 8'hA5);
        rd(2'd0, v); chk("R12 keyen", v, 8'hA5);
        wr(2'd1, 8'h01);
        rd(2'd1, v); chk("R12 dirb", v, 8'h01);
        rd(2'd2, v); chk("R12 mode", v, 8'h80);

        // R2 exact timing on pin 0
        port_a_in = 8'hFF; pin_b0_in = 1'b1;
        idle(4);
        wr(2'd2, 8'hC0);
        @(negedge clk) port_a_in = 8'hFE;
        idle(2);
        chk("R2 not before third edge", {7'b0, irq_req}, 8'h00);
        idle(1);
        chk("R2 third edge", {7'b0, irq_req}, 8'h01);

        // R7 sticky
        port_a_in = 8'hFF;
        idle(30);
        chk("R7 sticky", {7'b0, irq_req}, 8'h01);

        // R8 zero write no effect, clear bit reads 0
        wr(2'd2, 8'h80);
        chk("R8 zero write", {7'b0, irq_req}, 8'h01);
        rd(2'd2, v); chk("R8 reads zero", v, 8'h80);

        // R9 edge coincides with clear
        @(negedge clk) port_a_in = 8'hFE;
        idle(2);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'hC0;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
        chk("R9 edge wins", {7'b0, irq_req}, 8'h01);
        wr(2'd2, 8'hC0);
        chk("R8 clear", {7'b0, irq_req}, 8'h00);

        // R6 master off
        port_a_in = 8'hFF;
        idle(4);
        wr(2'd2, 8'h00);
        port_a_in = 8'hFE;
        idle(5);
        chk("R6 masked", {7'b0, irq_req}, 8'h00);
        wr(2'd2, 8'h80);
        idle(2);
        chk("R6 not recorded", {7'b0, irq_req}, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule